// File: doc/BRIEF.md
# Single-Shot Reload Down-Counter Timer

This block is a down-counting timer that runs once per start. Software writes a reload value into a holding register. A start comes either from a software trigger or from a rising edge on an external trigger pin. Either kind of start loads that value into the counter. The counter then decrements on each count-clock strobe until it passes through zero.

When the count passes from zero it wraps to all-ones. At that point the counter parks, raises a sticky underflow flag and waits for the next start. A level output stays high for the whole counting interval, so it forms one rectangular pulse per shot. An interrupt request is raised while the flag is set and interrupts are enabled.

A start that arrives during a count restarts the shot from the reload value. Clearing the enable stops the count at once.

Top module: `oneshot_reload_timer`

## Requirements
- R1: While counting, the counter decreases by exactly one on each clock edge where `tick` is 1, and holds its value on edges where `tick` is 0.
- R2: A start is accepted only when the enable is 1 after the current write. A software trigger written together with enable 0, or an external rising edge while disabled, leaves the counter and `tmr_out` unchanged.
- R3: A control write sets enable from `wdata[0]`, software trigger from `wdata[1]` and interrupt enable from `wdata[2]`. A write with both `wdata[0]` and `wdata[1]` set starts a shot. The reload value appears on `count` one clock after the write edge, on the second rising edge counting from the write.
- R4: When a `tick` arrives with the count at 0x0000, the counter becomes 0xFFFF and counting stops. It stays at 0xFFFF, whatever `tick` does, until the next start.
- R5: Underflow sets `uf_flag`. The flag stays set until a control write with `wdata[3]` = 0. A write with `wdata[3]` = 1 leaves the flag unchanged. If an underflow and a clearing write fall in the same cycle, the underflow wins.
- R6: `irq` is 1 exactly when `uf_flag` is 1 and the interrupt enable is 1.
- R7: `tmr_out` is 1 from the edge that loads the reload value until the underflow edge, and 0 otherwise.
- R8: A control write with `wdata[0]` = 0 stops counting on that edge. `tmr_out` goes to 0 and `count` keeps its current value.
- R9: `ext_trig` is asynchronous and is synchronized through two flops. With the block enabled, a 0-to-1 change loads the counter on the third rising edge after the edge that first samples it high.
- R10: A start received while a shot is in progress reloads the counter and continues counting from the reload value.
- R11: After reset, `count` is 0xFFFF and `tmr_out`, `uf_flag` and `irq` are 0. Enable, interrupt enable and the reload value are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_ctrl | input | 1 | Write strobe for the control fields in `wdata[3:0]` |
| wr_reload | input | 1 | Write strobe for the reload value |
| wdata | input | 16 | Write data |
| tick | input | 1 | Count-clock strobe, one cycle wide |
| ext_trig | input | 1 | Asynchronous external start, rising-edge active |
| count | output | 16 | Current counter value |
| tmr_out | output | 1 | High while a shot is being counted |
| uf_flag | output | 1 | Sticky underflow flag |
| irq | output | 1 | Interrupt request |

## Verification
Each result has a fixed latency after its stimulus:

- A software start shows on `count` and `tmr_out` two rising edges after the write edge is presented.
- An external edge shows three edges after it is first sampled.
- Decrements, the underflow wrap, the flag, the stop on disable and the interrupt follow on the very edge that samples their cause.

The bench carries a behavioural model that steps on the same edges. It keeps a queue of past `ext_trig` samples and a one-cycle pending start. It is compared with every output at each falling edge, so any result that comes a cycle early or late is flagged. Directed checks at the edges named in the requirements confirm these latencies explicitly.

// File: rtl/oneshot_timer_pkg.sv
// Package: shared width and control-field positions for the single-shot timer.
// Assumes the control fields sit in the low four bits of the write data.
package oneshot_timer_pkg;
    localparam int unsigned CNT_W  = 16;
    localparam int unsigned F_EN   = 0;  // count enable
    localparam int unsigned F_TRG  = 1;  // software start, self-clearing
    localparam int unsigned F_IE   = 2;  // interrupt enable
    localparam int unsigned F_UF   = 3;  // write 0 clears the underflow flag
endpackage

// File: rtl/tmr_edge_sync.sv
// Module: brings an asynchronous level into the clock domain through STAGES
// flops and reports a single-cycle pulse on each 0-to-1 change.
// Assumes STAGES >= 2; the input needs no relation to clk.
module tmr_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    localparam int unsigned LAST = STAGES;

    logic [LAST:0] chain;

    // Shift the input through the synchronizer plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[LAST-1:0], async_in};
    end

    assign rise = chain[LAST-1] & ~chain[LAST];
endmodule

// File: rtl/tmr_ctrl_regs.sv
// Module: control state of the timer - enable, interrupt enable, sticky
// underflow flag, reload holding register and the registered start request.
// Assumes wr_ctrl and wr_reload are single-cycle strobes.
module tmr_ctrl_regs
    import oneshot_timer_pkg::*;
#(
    parameter int unsigned W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_ctrl,
    input  logic         wr_reload,
    input  logic [W-1:0] wdata,
    input  logic         ext_rise,
    input  logic         uf_pulse,
    output logic         en_q,
    output logic         ie_q,
    output logic         uf_q,
    output logic [W-1:0] reload_q,
    output logic         start_q,
    output logic         stop
);
    logic en_next;
    logic trig_any;

    assign en_next  = wr_ctrl ? wdata[F_EN] : en_q;
    assign trig_any = (wr_ctrl & wdata[F_TRG]) | ext_rise;
    assign stop     = wr_ctrl & ~wdata[F_EN];

    // Enable, interrupt enable and the one-cycle start request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            ie_q    <= 1'b0;
            start_q <= 1'b0;
        end else begin
            en_q    <= en_next;
            start_q <= en_next & trig_any;
            if (wr_ctrl) ie_q <= wdata[F_IE];
        end
    end

    // Sticky underflow flag: set beats software clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                        uf_q <= 1'b0;
        else if (uf_pulse)                 uf_q <= 1'b1;
        else if (wr_ctrl && !wdata[F_UF])  uf_q <= 1'b0;
    end

    // Reload holding register.
    always_ff @(posedge clk) begin
        if (!rst_n)         reload_q <= '0;
        else if (wr_reload) reload_q <= wdata;
    end

    AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |-> en_q);  // R2
    AST_UF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        uf_pulse |=> uf_q);  // R5
endmodule

// File: rtl/tmr_down_counter.sv
// Module: the down-counter and its running state. Load beats tick; stop beats
// load. On passing zero it parks at all-ones and emits a one-cycle uf_pulse.
// Assumes load is a single-cycle request already qualified by enable.
module tmr_down_counter #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         stop,
    input  logic         tick,
    input  logic [W-1:0] reload,
    output logic [W-1:0] cnt,
    output logic         run_q,
    output logic         uf_pulse
);
    localparam logic [W-1:0] ALL_ONES = '1;

    logic at_zero;
    assign at_zero  = (cnt == '0);
    assign uf_pulse = !stop && !load && run_q && tick && at_zero;

    // Counter value and running state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= ALL_ONES;
            run_q <= 1'b0;
        end else if (stop) begin
            run_q <= 1'b0;
        end else if (load) begin
            cnt   <= reload;
            run_q <= 1'b1;
        end else if (run_q && tick) begin
            if (at_zero) begin
                cnt   <= ALL_ONES;
                run_q <= 1'b0;
            end else begin
                cnt   <= cnt - 1'b1;
            end
        end
    end

    AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && tick && !at_zero && !load && !stop) |=> (cnt == $past(cnt) - 1'b1));  // R1
    AST_PARK_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && tick && at_zero && !load && !stop) |=> (cnt == ALL_ONES && !run_q));  // R4
    AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !stop) |=> (run_q && cnt == $past(reload)));  // R10
    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (!run_q && $stable(cnt)));  // R8
endmodule

// File: rtl/oneshot_reload_timer.sv
// Module: top of the single-shot reload down-counter timer. Wires the
// external trigger synchronizer, control registers and counter together.
// Assumes a single clock; ext_trig may be asynchronous.
module oneshot_reload_timer
    import oneshot_timer_pkg::*;
#(
    parameter int unsigned W           = CNT_W,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_ctrl,
    input  logic         wr_reload,
    input  logic [W-1:0] wdata,
    input  logic         tick,
    input  logic         ext_trig,
    output logic [W-1:0] count,
    output logic         tmr_out,
    output logic         uf_flag,
    output logic         irq
);
    logic         ext_rise;
    logic         uf_pulse;
    logic         en_q;
    logic         ie_q;
    logic         start_q;
    logic         stop;
    logic [W-1:0] reload_q;
    logic         run_q;

    tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ext_trig),
        .rise     (ext_rise)
    );

    tmr_ctrl_regs #(.W(W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctrl   (wr_ctrl),
        .wr_reload (wr_reload),
        .wdata     (wdata),
        .ext_rise  (ext_rise),
        .uf_pulse  (uf_pulse),
        .en_q      (en_q),
        .ie_q      (ie_q),
        .uf_q      (uf_flag),
        .reload_q  (reload_q),
        .start_q   (start_q),
        .stop      (stop)
    );

    tmr_down_counter #(.W(W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start_q),
        .stop     (stop),
        .tick     (tick),
        .reload   (reload_q),
        .cnt      (count),
        .run_q    (run_q),
        .uf_pulse (uf_pulse)
    );

    assign tmr_out = run_q;
    assign irq     = uf_flag & ie_q;

    AST_IDLE_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> !run_q);  // R8
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> uf_flag);  // R6
endmodule

// File: tb/test_oneshot_reload_timer.sv
module test_oneshot_reload_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_ctrl = 1'b0;
    logic        wr_reload = 1'b0;
    logic [15:0] wdata = '0;
    logic        tick = 1'b0;
    logic        ext_trig = 1'b0;
    logic [15:0] count;
    logic        tmr_out;
    logic        uf_flag;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    int tick_div = 1;
    int tick_cnt = 0;
    string phase = "R11";

    // Reference model state
    logic [15:0] m_cnt, m_reload;
    logic        m_run, m_en, m_ie, m_uf, m_start;
    logic        hist[$];

    oneshot_reload_timer i_oneshot_reload_timer (
        .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_reload(wr_reload),
        .wdata(wdata), .tick(tick), .ext_trig(ext_trig), .count(count),
        .tmr_out(tmr_out), .uf_flag(uf_flag), .irq(irq)
    );

    always #10 clk = ~clk;  // 50 MHz

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Behavioural model, stepped on each rising edge from bench inputs only.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual %0d expected <= 100000", cycles);
            report();
        end
        if (!rst_n) begin
            m_cnt = 16'hFFFF; m_reload = 0; m_run = 0; m_en = 0; m_ie = 0;
            m_uf = 0; m_start = 0;
            hist = '{0, 0, 0, 0};
        end else begin
            bit rise, en_n, stop, uf_ev, new_start;
            hist.push_front(ext_trig);
            void'(hist.pop_back());
            rise = hist[2] && !hist[3];
            en_n = wr_ctrl ? wdata[0] : m_en;
            stop = wr_ctrl && !wdata[0];
            new_start = en_n && ((wr_ctrl && wdata[1]) || rise);
            uf_ev = 0;
            if (stop) m_run = 0;
            else if (m_start) begin m_cnt = m_reload; m_run = 1; end
            else if (m_run && tick) begin
                if (m_cnt == 0) begin m_cnt = 16'hFFFF; m_run = 0; uf_ev = 1; end
                else m_cnt = m_cnt - 1;
            end
            if (uf_ev) m_uf = 1;
            else if (wr_ctrl && !wdata[3]) m_uf = 0;
            if (wr_ctrl) m_ie = wdata[2];
            if (wr_reload) m_reload = wdata;
            m_start = new_start;
            m_en = en_n;
        end
    end

    // Compare every output with the model at each falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            n_tests++;
            if (count !== m_cnt || tmr_out !== m_run || uf_flag !== m_uf ||
                irq !== (m_uf & m_ie)) begin
                n_fail++;
                $display("FAIL %s cycle %0d: actual cnt=%0h out=%0b uf=%0b irq=%0b expected cnt=%0h out=%0b uf=%0b irq=%0b",
                         phase, cycles, count, tmr_out, uf_flag, irq,
                         m_cnt, m_run, m_uf, m_uf & m_ie);
            end
        end
    end

    // Count-clock strobe generator: one pulse every tick_div cycles.
    always @(negedge clk) begin
        tick_cnt = tick_cnt + 1;
        if (tick_cnt >= tick_div) begin tick <= 1'b1; tick_cnt = 0; end
        else tick <= 1'b0;
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_c(input bit en, input bit trg, input bit ie, input bit ufk);
        @(negedge clk);
        wr_ctrl = 1'b1; wdata = {12'h0, ufk, ie, trg, en};
        @(negedge clk);
        wr_ctrl = 1'b0;
    endtask

    task automatic wr_r(input logic [15:0] v);
        @(negedge clk);
        wr_reload = 1'b1; wdata = v;
        @(negedge clk);
        wr_reload = 1'b0;
    endtask

    initial begin
        logic [15:0] held;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk(count == 16'hFFFF, "R11", "count", count, 16'hFFFF);
        chk(!tmr_out && !uf_flag && !irq, "R11", "out/uf/irq", {tmr_out, uf_flag, irq}, 0);

        // R2: starts while disabled are ignored
        phase = "R2";
        wr_r(16'd10);
        wr_c(0, 1, 0, 1);
        idle(4);
        chk(!tmr_out && count == 16'hFFFF, "R2", "sw trig disabled", count, 16'hFFFF);
        ext_trig = 1'b1; idle(3); ext_trig = 1'b0; idle(6);
        chk(!tmr_out && count == 16'hFFFF, "R2", "ext trig disabled", count, 16'hFFFF);

        // R3: enable and trigger together; R7 output during shot
        phase = "R3";
        wr_c(1, 1, 1, 1);
        @(negedge clk);
        chk(count == 16'd10 && tmr_out, "R3", "load latency", count, 10);
        phase = "R7";
        idle(6);
        chk(tmr_out == 1'b1, "R7", "output while counting", tmr_out, 1);
        idle(8);
        // R4 / R5 / R6 after underflow
        phase = "R4";
        chk(count == 16'hFFFF && !tmr_out, "R4", "parked", count, 16'hFFFF);
        chk(uf_flag == 1'b1, "R5", "flag set", uf_flag, 1);
        chk(irq == 1'b1, "R6", "irq with ie", irq, 1);
        idle(5);
        chk(count == 16'hFFFF, "R4", "stays parked", count, 16'hFFFF);

        // R6: irq masked by ie, flag kept by wdata[3]=1
        phase = "R6";
        wr_c(1, 0, 0, 1);
        chk(uf_flag && !irq, "R6", "irq masked", irq, 0);
        wr_c(1, 0, 1, 1);
        chk(irq == 1'b1, "R6", "irq unmasked", irq, 1);

        // R5: clear flag
        phase = "R5";
        wr_c(1, 0, 1, 0);
        chk(uf_flag == 1'b0 && irq == 1'b0, "R5", "flag cleared", uf_flag, 0);

        // R1: slower count clock
        phase = "R1";
        tick_div = 3;
        wr_r(16'd4);
        wr_c(1, 1, 1, 1);
        idle(25);
        chk(count == 16'hFFFF && uf_flag, "R1", "slow count finished", count, 16'hFFFF);

        // R9: external trigger
        phase = "R9";
        tick_div = 1;
        wr_r(16'd6);
        @(negedge clk); ext_trig = 1'b1;
        idle(3);
        chk(tmr_out == 1'b0, "R9", "not yet loaded", tmr_out, 0);
        @(negedge clk);
        chk(tmr_out == 1'b1 && count == 16'd6, "R9", "loaded on third edge", count, 6);
        ext_trig = 1'b0;
        idle(12);

        // R10: retrigger during a shot
        phase = "R10";
        wr_r(16'd20);
        wr_c(1, 1, 0, 1);
        idle(6);
        wr_c(1, 1, 0, 1);
        @(negedge clk);
        chk(count == 16'd20 && tmr_out, "R10", "reload on retrigger", count, 20);
        idle(25);

        // R8: disable mid-count
        phase = "R8";
        wr_c(1, 1, 0, 1);
        idle(4);
        wr_c(0, 0, 0, 1);
        held = count;
        chk(tmr_out == 1'b0, "R8", "output dropped", tmr_out, 0);
        idle(4);
        chk(count == held, "R8", "count held", count, held);

        // R4 corner: reload of zero underflows on the first tick
        phase = "R4";
        wr_r(16'd0);
        wr_c(1, 1, 1, 1);
        @(negedge clk);
        chk(count == 16'd0 && tmr_out, "R4", "zero loaded", count, 0);
        @(negedge clk);
        chk(count == 16'hFFFF && !tmr_out && uf_flag, "R4", "zero underflow", count, 16'hFFFF);
        idle(4);

        report();
    end
endmodule